// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Register

This block is the digital front end of a two-channel 10-bit converter. A host sends a 16-bit command word over a three-wire serial link made up of an active-low chip select, a serial clock and a data line. The block oversamples the three lines with its own system clock. It shifts the data in most significant bit first on each falling serial clock edge that arrives while chip select is low. When chip select rises, it decodes the word.

A decoded word updates one of three storage elements: output latch A, output latch B, or a shared double buffer. Staging a value in the buffer does not change channel B's output. The next channel-A write loads latch A and copies the buffer into latch B on the same clock, so both outputs move together. Each accepted word also sets a speed-mode output and a power-control output. The two latch values are the block's parallel outputs.

Top module: `dual_dac_front`

## Requirements
- R1: After a synchronous active-low reset, `dac_a`, `dac_b` and the double buffer are zero, `fast_mode` is 0 and `pwr_down` is 1.
- R2: Data is taken from `sdi` on each falling `sclk` edge while `cs_n` is low, most significant bit first. The word is decoded when `cs_n` rises. The outputs take their new values at the third rising `clk` edge after `cs_n` goes high.
- R3: A word with bit 15 = 1 loads bits 11..2 into `dac_a` and, on the same clock, copies the double buffer into `dac_b`. When the buffer already equals latch B, `dac_b` does not change.
- R4: A word with bit 15 = 0 and bit 12 = 0 loads bits 11..2 into both the double buffer and `dac_b`. `dac_a` is unchanged.
- R5: A word with bit 15 = 0 and bit 12 = 1 loads bits 11..2 into the double buffer only. Both `dac_a` and `dac_b` keep their values until a later channel-A write moves the staged value to `dac_b`.
- R6: Every accepted word copies bit 14 to `fast_mode` (1 = fast, 0 = slow).
- R7: Every accepted word sets `pwr_down` to the inverse of bit 13 (bit 13 = 1 means active). While `pwr_down` is asserted, both latches and the buffer keep their contents.
- R8: Bits 1..0 of the word are ignored. Words that differ only in those bits produce identical outputs.
- R9: A frame with fewer or more than 16 falling `sclk` edges is discarded. No latch, buffer or mode output changes.
- R10: `sclk` edges while `cs_n` is high shift nothing and do not count toward the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Serial frame select, active low |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| sdi | input | 1 | Serial data, most significant bit first |
| dac_a | output | 10 | Channel A latch value |
| dac_b | output | 10 | Channel B latch value |
| fast_mode | output | 1 | Speed mode from the last accepted word |
| pwr_down | output | 1 | High when the last accepted word requested power-down |

## Verification
Every serial line passes through two synchronizer flops and then an edge detector. A frame's effect therefore lands on the third rising `clk` edge after `cs_n` rises. The bench raises `cs_n` on a falling `clk` edge, waits for three rising edges, and compares all four outputs at the next falling edge against its reference model. Each serial clock phase is held for four system clocks, so every falling `sclk` edge has finished shifting before the next edge or the end of the frame. The double buffer has no port of its own. The bench checks it through the `dac_b` value that a following channel-A write exposes.

// File: rtl/dual_dac_front.sv
module dual_dac_front #(
  parameter int CODE_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic [CODE_W-1:0] dac_a,
  output logic [CODE_W-1:0] dac_b,
  output logic              fast_mode,
  output logic              pwr_down
);
  localparam int WORD_W = CODE_W + 6;
  localparam int CNT_W  = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

  logic [SYNC_STAGES-1:0] cs_sync, sclk_sync, sdi_sync;
  logic                   cs_d, sclk_d;
  logic [WORD_W-1:0]      shreg;
  logic [CNT_W-1:0]       cnt;
  logic [CODE_W-1:0]      dbuf_q, lat_a_q, lat_b_q;
  logic                   fast_q, active_q;

  logic cs_s, sclk_s, sdi_s;
  assign cs_s   = cs_sync[SYNC_STAGES-1];
  assign sclk_s = sclk_sync[SYNC_STAGES-1];
  assign sdi_s  = sdi_sync[SYNC_STAGES-1];

  logic shift_w, cs_fall_w, apply_w;
  assign shift_w   = sclk_d & ~sclk_s & ~cs_s;
  assign cs_fall_w = cs_d & ~cs_s;
  assign apply_w   = ~cs_d & cs_s & (cnt == CNT_FULL);

  logic              sel_a, spd, pwr_on, buf_only;
  logic [CODE_W-1:0] field;
  assign sel_a    = shreg[WORD_W-1];
  assign spd      = shreg[WORD_W-2];
  assign pwr_on   = shreg[WORD_W-3];
  assign buf_only = shreg[WORD_W-4];
  assign field    = shreg[CODE_W+1:2];

  logic unused_dc;
  assign unused_dc = ^shreg[1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_sync   <= '1;
      sclk_sync <= '0;
      sdi_sync  <= '0;
      cs_d      <= 1'b1;
      sclk_d    <= 1'b0;
    end else begin
      cs_sync   <= {cs_sync[SYNC_STAGES-2:0], cs_n};
      sclk_sync <= {sclk_sync[SYNC_STAGES-2:0], sclk};
      sdi_sync  <= {sdi_sync[SYNC_STAGES-2:0], sdi};
      cs_d      <= cs_s;
      sclk_d    <= sclk_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (cs_fall_w) begin
      cnt <= '0;
    end else if (shift_w) begin
      shreg <= {shreg[WORD_W-2:0], sdi_s};
      if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dbuf_q   <= '0;
      lat_a_q  <= '0;
      lat_b_q  <= '0;
      fast_q   <= 1'b0;
      active_q <= 1'b0;
    end else if (apply_w) begin
      fast_q   <= spd;
      active_q <= pwr_on;
      if (sel_a) begin
        lat_a_q <= field;
        lat_b_q <= dbuf_q;
      end else begin
        dbuf_q <= field;
        if (!buf_only) lat_b_q <= field;
      end
    end
  end

  assign dac_a     = lat_a_q;
  assign dac_b     = lat_b_q;
  assign fast_mode = fast_q;
  assign pwr_down  = ~active_q;
endmodule

module dual_dac_front_chk #(
  parameter int CODE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              apply,
  input logic              sel_a,
  input logic              spd,
  input logic              pwr_on,
  input logic              buf_only,
  input logic [CODE_W-1:0] field,
  input logic [CODE_W-1:0] dbuf,
  input logic [CODE_W-1:0] dac_a,
  input logic [CODE_W-1:0] dac_b,
  input logic              fast_mode,
  input logic              pwr_down
);
  logic was_rst;
  always_ff @(posedge clk) was_rst <= !rst_n;

  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    was_rst |-> (dac_a == '0 && dac_b == '0 && dbuf == '0 && !fast_mode && pwr_down));

  a_r3_a_write: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && sel_a) |=> (dac_a == $past(field) && dac_b == $past(dbuf)));

  a_r4_b_write: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && !sel_a && !buf_only) |=> (dac_b == $past(field) && dbuf == $past(field) && $stable(dac_a)));

  a_r5_buf_only: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && !sel_a && buf_only) |=> ($stable(dac_a) && $stable(dac_b) && dbuf == $past(field)));

  a_r6_speed: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> (fast_mode == $past(spd)));

  a_r7_power: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> (pwr_down == !$past(pwr_on)));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> ($stable(dac_a) && $stable(dac_b) && $stable(dbuf) && $stable(fast_mode) && $stable(pwr_down)));
endmodule

bind dual_dac_front dual_dac_front_chk #(.CODE_W(CODE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .apply(apply_w), .sel_a(sel_a), .spd(spd),
  .pwr_on(pwr_on), .buf_only(buf_only), .field(field), .dbuf(dbuf_q),
  .dac_a(dac_a), .dac_b(dac_b), .fast_mode(fast_mode), .pwr_down(pwr_down)
);

// File: tb/dual_dac_front_tb.sv
module dual_dac_front_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PHASE = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [9:0] dac_a, dac_b;
  logic fast_mode, pwr_down;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  logic [9:0] m_a = '0, m_b = '0, m_buf = '0;
  logic m_fast = 1'b0, m_pd = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_dac_front dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .dac_a(dac_a), .dac_b(dac_b), .fast_mode(fast_mode), .pwr_down(pwr_down)
  );

  function automatic logic [9:0] fld(input logic [15:0] w);
    return w[11:2];
  endfunction

  task automatic model_apply(input logic [15:0] w);
    m_fast = w[14];
    m_pd   = ~w[13];
    if (w[15]) begin
      m_b = m_buf;
      m_a = fld(w);
    end else begin
      m_buf = fld(w);
      if (!w[12]) m_b = fld(w);
    end
  endtask

  task automatic check(input string req, input string what, input logic [9:0] act, input logic [9:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check(req, "dac_a", dac_a, m_a);
    check(req, "dac_b", dac_b, m_b);
    check(req, "fast_mode", {9'd0, fast_mode}, {9'd0, m_fast});
    check(req, "pwr_down", {9'd0, pwr_down}, {9'd0, m_pd});
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R2: one frame with nbits falling sclk edges; model updated only on 16
  task automatic send(input logic [15:0] w, input int nbits, input string req);
    @(negedge clk);
    cs_n = 1'b0;
    wait_clk(PHASE);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b1;
      sdi = (i < 16) ? w[15-i] : 1'b1;
      wait_clk(PHASE);
      sclk = 1'b0;
      wait_clk(PHASE);
    end
    wait_clk(PHASE);
    cs_n = 1'b1;
    if (nbits == 16) model_apply(w);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all(req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    void'($urandom(32'd4242));
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(2);
    check_all("R1");

    // R2: outputs not yet changed two edges after cs_n rises
    @(negedge clk); cs_n = 1'b0; wait_clk(PHASE);
    for (int i = 0; i < 16; i++) begin
      sclk = 1'b1; sdi = w_bit(16'hEFFF, i); wait_clk(PHASE);
      sclk = 1'b0; wait_clk(PHASE);
    end
    wait_clk(PHASE);
    cs_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_all("R2 early");
    model_apply(16'hEFFF);
    @(negedge clk);
    check_all("R2 R3");

    send(16'b0110_1111_1111_1100, 16, "R4");
    send(16'b0111_1000_0000_0000, 16, "R5");
    send(16'hE554, 16, "R3 R5");
    check(  "R3", "b from buffer", dac_b, 10'h200);
    send(16'hE555, 16, "R3 R8");
    check(  "R8", "a ignores low bits", dac_a, 10'h155);
    send(16'h4AAB, 16, "R7");
    check(  "R7", "latch kept", dac_a, 10'h155);
    send(16'h2000, 16, "R6");
    send(16'h5123, 15, "R9 short");
    send(16'h5123, 17, "R9 long");
    // R10: idle sclk toggles with cs_n high
    for (int k = 0; k < 5; k++) begin
      sclk = 1'b1; sdi = 1'b1; wait_clk(PHASE);
      sclk = 1'b0; wait_clk(PHASE);
    end
    check_all("R10 idle");
    send(16'hF0F0, 16, "R10 frame");

    for (int n = 0; n < 200; n++) begin
      int r;
      int nb;
      w = 16'($urandom);
      r = int'($urandom % 8);
      nb = (r == 0) ? 15 : (r == 1) ? 17 : 16;
      send(w, nb, "R3 R4 R5 R6 R7 R9 random");
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  function automatic logic w_bit(input logic [15:0] w, input int i);
    return w[15-i];
  endfunction
endmodule